// File: doc/BRIEF.md
# Background Pattern Shift Register

This block holds sixteen bits of background tile pattern data and feeds out one pattern bit per pixel. Each pixel takes two strobes of the system clock. On the first strobe the whole register is copied into a capture stage. On the second strobe the register is rebuilt from that copy, in one of two ways. In a shift, every bit moves one place toward index zero and a zero enters at bit 15. In a reload, the upper byte is taken from an 8-bit data input and the lower byte keeps its value.

The pixel output comes from the lower byte only. A 3-bit fine scroll input picks one of those eight bits without a clock. A fetch sequencer outside this block drives the phase strobes, the reload request and the data byte. Typically it requests a reload once every eight pixels.

Top module: `bgpat_shifter`

## Requirements
- R1: A synchronous active-high reset clears the register and the capture stage, so every fine scroll value gives output 0.
- R2: A cycle with only the phase-0 strobe high copies the register into the capture stage and leaves the register, and so the output, unchanged.
- R3: A phase-1 strobe with the reload request low sets register bit i to captured bit i+1 for i from 0 to 14. The bit seen at fine scroll k is therefore the bit that was seen at k+1 before the pixel.
- R4: During a shift, register bit 15 takes 0.
- R5: A phase-1 strobe with the reload request high sets register bits 15..8 to data bits 7..0, with data bit j going to register bit 8+j.
- R6: During a reload, register bits 7..0 keep their captured values and do not shift.
- R7: The reload request and data are sampled only on a phase-1 strobe. A reload request that is high on a phase-0 or idle cycle has no effect.
- R8: Phase-1 works from the value taken at the latest phase-0 strobe. A second phase-1 strobe with no phase-0 strobe in between leaves the register as the first one left it. The two strobes are never high together.
- R9: The output equals register bit fine_x, where fine_x is 0..7, and it follows a change of fine_x in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ph0_en | input | 1 | Phase-0 strobe: capture the register |
| ph1_en | input | 1 | Phase-1 strobe: shift or reload from the capture |
| load_req | input | 1 | Turns the phase-1 strobe into a reload |
| load_data | input | 8 | Byte placed in the upper half on a reload |
| fine_x | input | 3 | Selects which lower-half bit is output |
| pix_bit | output | 1 | Selected pattern bit |

## Verification
The bench goes after the two-phase hazards. If a second phase-1 strobe reused the live register instead of the capture, it would advance the pattern twice. If a reload also shifted the lower half, the last pixels of the previous tile would be lost. If a reload request were sampled outside phase-1, a pixel would be replaced with new data early. It also checks the zero that enters at the top. A design that fed back bit 0 or kept bit 15 would leave ones in the lower byte after the loaded data has passed through. A swept fine scroll catches a reversed or off-by-one tap.

// File: rtl/bgpat_pkg.sv
package bgpat_pkg;

    localparam int PAT_W_DEF  = 16;
    localparam int LOAD_W_DEF = 8;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_LOAD    = 2'd3
    } pix_op_e;

    // Phase-0 wins; the reload request only matters on phase-1.
    function automatic pix_op_e decode_op(input logic ph0, input logic ph1, input logic ld);
        pix_op_e op;
        if (ph0)
            op = OP_CAPTURE;
        else if (ph1)
            op = ld ? OP_LOAD : OP_SHIFT;
        else
            op = OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/bgpat_phase_ctl.sv
module bgpat_phase_ctl
    import bgpat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ph0_en,
    input  logic    ph1_en,
    input  logic    load_req,
    output pix_op_e op_o
);

    always_comb begin
        op_o = decode_op(ph0_en, ph1_en, load_req);
    end

    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ph0_en && ph1_en)); // R8

endmodule

// File: rtl/bgpat_capture.sv
module bgpat_capture
    import bgpat_pkg::*;
#(
    parameter int PAT_W = PAT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  pix_op_e          op_i,
    input  logic [PAT_W-1:0] stage_i,
    output logic [PAT_W-1:0] cap_o
);

    logic [PAT_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else if (op_i == OP_CAPTURE)
            cap_q <= stage_i;
    end

    assign cap_o = cap_q;

    AST_CAPTURE_TAKES_STAGE: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CAPTURE) |=> (cap_q == $past(stage_i))); // R2

    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_CAPTURE) |=> $stable(cap_q)); // R8

endmodule

// File: rtl/bgpat_advance.sv
module bgpat_advance
    import bgpat_pkg::*;
#(
    parameter int PAT_W  = PAT_W_DEF,
    parameter int LOAD_W = LOAD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  pix_op_e           op_i,
    input  logic [PAT_W-1:0]  cap_i,
    input  logic [LOAD_W-1:0] data_i,
    output logic [PAT_W-1:0]  stage_o
);

    localparam int LOAD_LO = PAT_W - LOAD_W;

    logic [PAT_W-1:0] stage_q;
    logic [PAT_W-1:0] nxt_shift;
    logic [PAT_W-1:0] nxt_load;

    for (genvar i = 0; i < PAT_W; i++) begin : g_bit
        if (i == PAT_W - 1) begin : g_top
            assign nxt_shift[i] = 1'b0;
        end else begin : g_mid
            assign nxt_shift[i] = cap_i[i+1];
        end
        if (i >= LOAD_LO) begin : g_ld
            assign nxt_load[i] = data_i[i-LOAD_LO];
        end else begin : g_keep
            assign nxt_load[i] = cap_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else if (op_i == OP_SHIFT)
            stage_q <= nxt_shift;
        else if (op_i == OP_LOAD)
            stage_q <= nxt_load;
    end

    assign stage_o = stage_q;

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SHIFT) |=> !stage_q[PAT_W-1]); // R4

    AST_LOAD_UPPER: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_LOAD) |=> (stage_q[PAT_W-1:LOAD_LO] == $past(data_i))); // R5

    AST_LOAD_LOWER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_LOAD) |=> (stage_q[LOAD_LO-1:0] == $past(cap_i[LOAD_LO-1:0]))); // R6

    AST_HOLD_OFF_PHASE1: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_IDLE || op_i == OP_CAPTURE) |=> $stable(stage_q)); // R2

endmodule

// File: rtl/bgpat_tap.sv
module bgpat_tap #(
    parameter int TAP_W = 8,
    localparam int SEL_W = $clog2(TAP_W)
) (
    input  logic [TAP_W-1:0] low_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             bit_o
);

    always_comb begin
        bit_o = low_i[sel_i];
    end

endmodule

// File: rtl/bgpat_shifter.sv
module bgpat_shifter
    import bgpat_pkg::*;
#(
    parameter int PAT_W  = PAT_W_DEF,
    parameter int LOAD_W = LOAD_W_DEF,
    localparam int TAP_W = PAT_W - LOAD_W,
    localparam int FX_W  = $clog2(TAP_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ph0_en,
    input  logic              ph1_en,
    input  logic              load_req,
    input  logic [LOAD_W-1:0] load_data,
    input  logic [FX_W-1:0]   fine_x,
    output logic              pix_bit
);

    pix_op_e          op;
    logic [PAT_W-1:0] stage;
    logic [PAT_W-1:0] cap;

    bgpat_phase_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ph0_en   (ph0_en),
        .ph1_en   (ph1_en),
        .load_req (load_req),
        .op_o     (op)
    );

    bgpat_capture #(.PAT_W(PAT_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .stage_i (stage),
        .cap_o   (cap)
    );

    bgpat_advance #(.PAT_W(PAT_W), .LOAD_W(LOAD_W)) u_adv (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .cap_i   (cap),
        .data_i  (load_data),
        .stage_o (stage)
    );

    bgpat_tap #(.TAP_W(TAP_W)) u_tap (
        .low_i (stage[TAP_W-1:0]),
        .sel_i (fine_x),
        .bit_o (pix_bit)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (stage == '0)); // R1

endmodule

// File: tb/bgpat_shifter_tb_top.sv
module bgpat_shifter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ph0_en = 1'b0;
    logic       ph1_en = 1'b0;
    logic       load_req = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic [2:0] fine_x = 3'd0;
    logic       pix_bit;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model = 16'h0000;

    always #10 clk = ~clk;

    bgpat_shifter dut_i (
        .clk       (clk),
        .rst       (rst),
        .ph0_en    (ph0_en),
        .ph1_en    (ph1_en),
        .load_req  (load_req),
        .load_data (load_data),
        .fine_x    (fine_x),
        .pix_bit   (pix_bit)
    );

    // {reload, data}; a reload on every eighth pixel, junk data otherwise
    localparam logic [8:0] VEC [24] = '{
        9'h1A5, 9'h0FF, 9'h012, 9'h0C3, 9'h07E, 9'h000, 9'h0FF, 9'h055,
        9'h13C, 9'h0AA, 9'h0FF, 9'h001, 9'h080, 9'h0F0, 9'h00F, 9'h066,
        9'h1FF, 9'h0FF, 9'h000, 9'h0FF, 9'h05A, 9'h0A5, 9'h0C0, 9'h003
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s fine_x=%0d actual=%0b expected=%0b", req, fine_x, act, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < 8; k++) begin
            fine_x = k[2:0];
            #1;
            chk(req, pix_bit, model[k]);
        end
    endtask

    task automatic pixel(input logic ld, input logic [7:0] d);
        @(negedge clk);
        ph0_en = 1'b1; ph1_en = 1'b0; load_req = 1'b0;
        @(negedge clk);
        ph0_en = 1'b0; ph1_en = 1'b1; load_req = ld; load_data = d;
        @(negedge clk);
        ph1_en = 1'b0; load_req = 1'b0;
        if (ld) model = {d, model[7:0]};
        else    model = model >> 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model = 16'h0000;
        sweep("R1");

        // table walk
        for (int v = 0; v < 24; v++) begin
            pixel(VEC[v][8], VEC[v][7:0]);
            if (VEC[v][8]) sweep("R5_R6");
            else           sweep("R3_R9");
        end

        // phase-0 alone changes nothing
        pixel(1'b1, 8'hC9);
        @(negedge clk); ph0_en = 1'b1;
        @(negedge clk); ph0_en = 1'b0;
        @(negedge clk);
        sweep("R2");

        // reload request outside phase-1 is ignored
        @(negedge clk); ph0_en = 1'b1; load_req = 1'b1; load_data = 8'hFF;
        @(negedge clk); ph0_en = 1'b0; load_req = 1'b1;
        @(negedge clk); ph1_en = 1'b1; load_req = 1'b0; load_data = 8'h00;
        @(negedge clk); ph1_en = 1'b0;
        model = model >> 1;
        sweep("R7");

        // second phase-1 without a new capture repeats the same result
        pixel(1'b1, 8'hAA);
        pixel(1'b0, 8'h00);
        @(negedge clk); ph1_en = 1'b1;
        @(negedge clk); ph1_en = 1'b0;
        sweep("R8");

        // zero entering at the top reaches the lower byte
        pixel(1'b1, 8'hFF);
        for (int s = 0; s < 9; s++) pixel(1'b0, 8'hFF);
        fine_x = 3'd7; #1;
        chk("R4", pix_bit, 1'b0);
        sweep("R4");

        // random scroll, reload every eight pixels
        for (int p = 0; p < 200; p++) begin
            logic [7:0] d;
            d = 8'($urandom);
            pixel((p % 8) == 0, d);
            fine_x = 3'($urandom);
            #1;
            chk("R9", pix_bit, model[fine_x]);
        end

        // reset in the middle of operation
        pixel(1'b1, 8'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model = 16'h0000;
        sweep("R1");
        pixel(1'b0, 8'hFF);
        sweep("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule